// File: doc/BRIEF.md
# Signed Fixed-Point Arithmetic Unit

This block performs one arithmetic step per clock on signed two's-complement fixed-point words. Each word holds `INT_W` integer bits, with the sign counted among them, and `FRAC_W` fraction bits. The default of four and four gives values from -8 to 7.9375 in steps of 1/16.

A 3-bit code selects one of five operations:

- add,
- subtract,
- multiply,
- integer-to-fixed conversion,
- fixed-to-integer conversion.

The answer is returned in the operand format one clock after the inputs are presented, together with two flags. The range flag reports that the true answer does not fit the format. The inexact flag reports that fraction bits were discarded.

Multiplication forms the full double-width product. It keeps the bits that line up with the operand format and truncates the low fraction bits. Conversions are plain shifts by the fraction width. The same source serves a 16.16 configuration by changing the two width parameters.

Top module: `fxp_alu`

## Requirements
- R1: With opSel = 0 (add), result is the two's-complement sum of opA and opB modulo 2^W, where W = INT_W+FRAC_W; inexact is 0.
- R2: For add, ovf is 1 exactly when both operands share a sign bit and the sign bit of the sum differs from it.
- R3: With opSel = 1 (subtract), result is opA minus opB modulo 2^W and inexact is 0. ovf is 1 when the true difference lies outside the signed W-bit range, and also whenever opB is the most negative word.
- R4: With opSel = 2 (multiply), result is bits [W+FRAC_W-1:FRAC_W] of the 2W-bit signed product, so the low fraction bits are truncated.
- R5: For multiply, ovf is 1 exactly when the true product, after dropping FRAC_W fraction bits, lies outside the signed W-bit range.
- R6: For multiply, inexact is 1 exactly when any of the FRAC_W least significant bits of the full product is 1.
- R7: With opSel = 3 (integer to fixed), opA is taken as a signed W-bit integer and result is opA shifted left by FRAC_W. ovf is 1 when opA lies outside [-2^(INT_W-1), 2^(INT_W-1)-1]; inexact is 0.
- R8: With opSel = 4 (fixed to integer), result is opA arithmetically shifted right by FRAC_W, so the fraction is truncated toward minus infinity. ovf is 0, and inexact is 1 when the dropped fraction bits are nonzero.
- R9: Codes 5, 6 and 7 give result 0 with ovf and inexact both 0, whatever the operands.
- R10: Outputs are registered. They show the answer for the inputs sampled at the previous rising edge, and are all zero while rst_n is low.
- R11: With INT_W = 16 and FRAC_W = 16, every rule above holds for 32-bit words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears the outputs |
| opA | input | INT_W+FRAC_W | First operand, or the value to convert |
| opB | input | INT_W+FRAC_W | Second operand, ignored by conversions |
| opSel | input | 3 | Operation code: 0 add, 1 sub, 2 mul, 3 int-to-fixed, 4 fixed-to-int |
| result | output | INT_W+FRAC_W | Registered answer in the operand format |
| ovf | output | 1 | Registered range flag |
| inexact | output | 1 | Registered precision-loss flag |

## Verification
The only state is the output register, so an internal fault appears in the first output word after the offending inputs. There is no earlier or later cycle in which it could show.

A wrong decode of the operation code shows as an answer belonging to another operation, or as a nonzero word for an unused code. A wrong choice of product bits shows as a result scaled by a power of two. A wrong flag term shows as a flag that disagrees with the exact integer answer the bench computes.

Both the narrow and the 16.16 instance are driven in lock-step. Slice errors that depend on the parameters therefore show up in at least one of them within one clock.

// File: rtl/fxp_pkg.sv
package fxp_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_MUL = 3'd2,
    OP_I2F = 3'd3,
    OP_F2I = 3'd4
  } fxOp_e;

  // one strobe per operation; at most one is high in a cycle
  typedef struct packed {
    logic doAdd;
    logic doSub;
    logic doMul;
    logic doI2F;
    logic doF2I;
  } fxStrobe_t;

endpackage

// File: rtl/fxp_ctrl.sv
module fxp_ctrl
  import fxp_pkg::*;
(
  input  logic [2:0] opSel,
  output fxStrobe_t  strobe
);

  always_comb begin
    strobe = '0;
    case (opSel)
      OP_ADD:  strobe.doAdd = 1'b1;
      OP_SUB:  strobe.doSub = 1'b1;
      OP_MUL:  strobe.doMul = 1'b1;
      OP_I2F:  strobe.doI2F = 1'b1;
      OP_F2I:  strobe.doF2I = 1'b1;
      default: strobe = '0;
    endcase
  end

  always_comb begin
    AST_ONE_STROBE: assert ($onehot0(strobe)); // R9
  end

endmodule

// File: rtl/fxp_dp.sv
module fxp_dp
  import fxp_pkg::*;
#(
  parameter int INT_W  = 4,
  parameter int FRAC_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  fxStrobe_t               strobe,
  input  logic [INT_W+FRAC_W-1:0] opA,
  input  logic [INT_W+FRAC_W-1:0] opB,
  output logic [INT_W+FRAC_W-1:0] result,
  output logic                    ovf,
  output logic                    inexact
);

  localparam int W     = INT_W + FRAC_W;
  localparam int PW    = 2 * W;
  localparam int TOP_N = PW - (W + FRAC_W - 1);   // product bits above the kept sign
  localparam int I2F_N = FRAC_W + 1;              // input bits that must match the sign

  // ---------------- add / subtract share one adder ----------------
  logic [W-1:0] addend, sum;
  logic         sameSign, addOvf, bIsMin;

  always_comb begin
    addend   = strobe.doSub ? (~opB + W'(1)) : opB;
    sum      = opA + addend;
    sameSign = (opA[W-1] == addend[W-1]);
    addOvf   = sameSign && (sum[W-1] != opA[W-1]);
    bIsMin   = (opB == {1'b1, {(W-1){1'b0}}});
  end

  // ---------------- multiply ----------------
  logic signed [PW-1:0] prodFull;
  logic [W-1:0]         mulRes;
  logic [TOP_N-1:0]     prodTop;
  logic                 mulOvf, mulInexact;

  always_comb begin
    prodFull   = $signed({{W{opA[W-1]}}, opA}) * $signed({{W{opB[W-1]}}, opB});
    mulRes     = prodFull[W+FRAC_W-1:FRAC_W];
    prodTop    = prodFull[PW-1:W+FRAC_W-1];
    mulOvf     = !((&prodTop) || !(|prodTop));
    mulInexact = |prodFull[FRAC_W-1:0];
  end

  // ---------------- conversions ----------------
  logic [W-1:0]     i2fRes, f2iRes;
  logic [I2F_N-1:0] i2fHigh;
  logic             i2fOvf, f2iInexact;

  always_comb begin
    i2fRes     = opA << FRAC_W;
    i2fHigh    = opA[W-1:INT_W-1];
    i2fOvf     = !((&i2fHigh) || !(|i2fHigh));
    f2iRes     = W'($signed(opA) >>> FRAC_W);
    f2iInexact = |opA[FRAC_W-1:0];
  end

  // ---------------- select and register ----------------
  logic [W-1:0] resNext;
  logic         ovfNext, inxNext;

  always_comb begin
    resNext = '0;
    ovfNext = 1'b0;
    inxNext = 1'b0;
    unique case (1'b1)
      strobe.doAdd: begin resNext = sum;    ovfNext = addOvf;          end
      strobe.doSub: begin resNext = sum;    ovfNext = addOvf | bIsMin; end
      strobe.doMul: begin resNext = mulRes; ovfNext = mulOvf; inxNext = mulInexact; end
      strobe.doI2F: begin resNext = i2fRes; ovfNext = i2fOvf;          end
      strobe.doF2I: begin resNext = f2iRes; inxNext = f2iInexact;      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result  <= '0;
      ovf     <= 1'b0;
      inexact <= 1'b0;
    end else begin
      result  <= resNext;
      ovf     <= ovfNext;
      inexact <= inxNext;
    end
  end

  // ---------------- assertions ----------------
  logic pastValid;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pastValid <= 1'b0;
    else        pastValid <= 1'b1;
  end

  AST_IDLE_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && $past(strobe) == '0) |-> (result == '0 && !ovf && !inexact)); // R9

  AST_INEXACT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    inexact |-> (pastValid && ($past(strobe.doMul) || $past(strobe.doF2I)))); // R6

  AST_F2I_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && $past(strobe.doF2I)) |-> !ovf); // R8

  AST_ADD_SIGN_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && $past(strobe.doAdd) && ($past(opA[W-1]) == $past(opB[W-1]))
      && (result[W-1] != $past(opA[W-1]))) |-> ovf); // R2

  AST_I2F_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && $past(strobe.doI2F)) |-> (result[FRAC_W-1:0] == '0)); // R7

  AST_SUB_MIN_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && $past(strobe.doSub) && $past(opB) == {1'b1, {(W-1){1'b0}}}) |-> ovf); // R3

endmodule

// File: rtl/fxp_alu.sv
module fxp_alu
  import fxp_pkg::*;
#(
  parameter int INT_W  = 4,
  parameter int FRAC_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [INT_W+FRAC_W-1:0] opA,
  input  logic [INT_W+FRAC_W-1:0] opB,
  input  logic [2:0]              opSel,
  output logic [INT_W+FRAC_W-1:0] result,
  output logic                    ovf,
  output logic                    inexact
);

  fxStrobe_t strobe;

  fxp_ctrl u_ctrl (
    .opSel  (opSel),
    .strobe (strobe)
  );

  fxp_dp #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .result  (result),
    .ovf     (ovf),
    .inexact (inexact)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (result == '0 && !ovf && !inexact)); // R10

endmodule

// File: tb/fxp_alu_test.sv
`timescale 1ns/1ps
module fxp_alu_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  opSel = 3'd0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [31:0] a32 = '0, b32 = '0;
  logic [7:0]  res8;
  logic [31:0] res32;
  logic        ovf8, inx8, ovf32, inx32;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  fxp_alu #(.INT_W(4), .FRAC_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .opA(a8), .opB(b8), .opSel(opSel),
    .result(res8), .ovf(ovf8), .inexact(inx8));

  fxp_alu #(.INT_W(16), .FRAC_W(16)) uutWide (
    .clk(clk), .rst_n(rst_n), .opA(a32), .opB(b32), .opSel(opSel),
    .result(res32), .ovf(ovf32), .inexact(inx32));

  // exact integer model of the requirements
  function automatic void model(input int w, input int f, input int op,
                                input longint a, input longint b,
                                output longint res, output bit ov, output bit ix);
    longint mn, mx, mask, fmask, t, lim;
    mn    = -(longint'(1) <<< (w - 1));
    mx    = -mn - 1;
    mask  = (longint'(1) <<< w) - 1;
    fmask = (longint'(1) <<< f) - 1;
    res = 0; ov = 0; ix = 0;
    case (op)
      0: begin t = a + b; ov = (t < mn) || (t > mx); res = t & mask; end
      1: begin t = a - b; ov = (b == mn) || (t < mn) || (t > mx); res = t & mask; end
      2: begin
        t  = a * b;
        ix = (t & fmask) != 0;
        t  = t >>> f;
        ov = (t < mn) || (t > mx);
        res = t & mask;
      end
      3: begin
        lim = longint'(1) <<< (w - f - 1);
        ov  = (a < -lim) || (a > lim - 1);
        res = (a <<< f) & mask;
      end
      4: begin ix = (a & fmask) != 0; res = (a >>> f) & mask; end
      default: ;
    endcase
  endfunction

  task automatic compare(input string tag, input string which,
                         input longint gotR, input bit gotO, input bit gotI,
                         input longint expR, input bit expO, input bit expI);
    checks++;
    if (gotR != expR || gotO != expO || gotI != expI) begin
      errors++;
      $display("FAIL %s %s: got res=%0h ovf=%0b inx=%0b expected res=%0h ovf=%0b inx=%0b",
               tag, which, gotR, gotO, gotI, expR, expO, expI);
    end
  endtask

  task automatic runOp(input logic [2:0] op, input logic [7:0] na, input logic [7:0] nb,
                       input logic [31:0] wa, input logic [31:0] wb, input string tag);
    longint eR; bit eO, eI;
    @(negedge clk);
    opSel = op; a8 = na; b8 = nb; a32 = wa; b32 = wb;
    @(posedge clk);
    #1;
    model(8, 4, int'(op), longint'($signed(na)), longint'($signed(nb)), eR, eO, eI);
    compare(tag, "Q4.4", longint'(res8), ovf8, inx8, eR, eO, eI);
    model(32, 16, int'(op), longint'($signed(wa)), longint'($signed(wb)), eR, eO, eI);
    compare({tag, " R11"}, "Q16.16", longint'(res32), ovf32, inx32, eR, eO, eI);
  endtask

  function automatic string tagFor(input logic [2:0] op);
    case (op)
      3'd0: return "R1 R2";
      3'd1: return "R3";
      3'd2: return "R4 R5 R6";
      3'd3: return "R7";
      3'd4: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    opSel = 3'd2; a8 = 8'h7F; b8 = 8'h7F; a32 = 32'h7FFF_FFFF; b32 = 32'h1234_5678;
    repeat (3) @(posedge clk);
    #1;
    compare("R10 reset", "Q4.4", longint'(res8), ovf8, inx8, 0, 0, 0);
    compare("R10 reset", "Q16.16", longint'(res32), ovf32, inx32, 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // directed corner cases
    runOp(3'd0, 8'h3A, 8'h41, 32'h0003_A000, 32'h0004_1000, "R1 add");
    runOp(3'd0, 8'h3A, 8'hE8, 32'h0003_A000, 32'hFFFE_8000, "R1 add negative");
    runOp(3'd0, 8'h6A, 8'h41, 32'h7FFF_0000, 32'h0001_0000, "R2 positive overflow");
    runOp(3'd0, 8'hA0, 8'hA0, 32'h8000_0000, 32'hFFFF_0000, "R2 negative overflow");
    runOp(3'd1, 8'h3A, 8'h18, 32'h0003_A000, 32'h0001_8000, "R3 sub");
    runOp(3'd1, 8'hF0, 8'h80, 32'hFFFF_0000, 32'h8000_0000, "R3 min subtrahend");
    runOp(3'd1, 8'h70, 8'hF0, 32'h7FFF_0000, 32'hFFFF_0000, "R3 sub overflow");
    runOp(3'd2, 8'h34, 8'h21, 32'h0003_4000, 32'h0002_1000, "R4 R6 mul truncate");
    runOp(3'd2, 8'h78, 8'h08, 32'h0007_8000, 32'h0000_8000, "R4 mul exact");
    runOp(3'd2, 8'h68, 8'h40, 32'h0100_0000, 32'h0100_0000, "R5 mul overflow");
    runOp(3'd2, 8'h80, 8'h80, 32'h8000_0000, 32'h8000_0000, "R5 min times min");
    runOp(3'd2, 8'hC0, 8'h20, 32'hFFFF_8000, 32'h0002_0000, "R5 negative in range");
    runOp(3'd3, 8'h07, 8'h00, 32'h0000_002A, 32'h0, "R7 int to fixed");
    runOp(3'd3, 8'h08, 8'h00, 32'h0000_8000, 32'h0, "R7 convert overflow");
    runOp(3'd3, 8'hF8, 8'h00, 32'hFFFF_8000, 32'h0, "R7 most negative integer");
    runOp(3'd4, 8'hD8, 8'h00, 32'h002C_E000, 32'h0, "R8 fixed to int");
    runOp(3'd4, 8'h30, 8'h55, 32'hFFFF_0000, 32'h1, "R8 whole value");
    runOp(3'd5, 8'h7F, 8'h7F, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9 unused code 5");
    runOp(3'd7, 8'h80, 8'h01, 32'h8000_0000, 32'h1, "R9 unused code 7");

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      logic [7:0] ra, rb;
      logic [31:0] wa, wb;
      op = 3'($urandom_range(7, 0));
      ra = 8'($urandom);
      rb = 8'($urandom);
      wa = $urandom;
      wb = $urandom;
      if (op == 3'd2 && ($urandom % 2) == 0) begin
        wa = 32'($signed(wa) >>> 12);
        wb = 32'($signed(wb) >>> 12);
      end
      if (op == 3'd3 && ($urandom % 2) == 0) begin
        ra = 8'($signed(ra) >>> 4);
        wa = 32'($signed(wa) >>> 16);
      end
      runOp(op, ra, rb, wa, wb, tagFor(op));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule